// File: doc/BRIEF.md
# Remote DMA Channel Controller

This block moves data between a host register interface and a local buffer memory, one data-port access at a time. Software programs a 16-bit start address and a 16-bit byte count through byte-wide register writes, then issues a 3-bit command that starts a memory-to-host transfer (read) or a host-to-memory transfer (write). Every access to the data-port register moves one byte or one 16-bit word, depending on the transfer-width input. The current address advances by the same step, and the remaining count drops by the same step.

For reads, the channel fetches the next memory location ahead of time, so that the data-port register already holds valid data when the host reads it. A one-cycle completion pulse marks the end of a transfer. A command with its top bit set aborts at once. After an abort the current address keeps its last value, and it is not reloaded from the start address. The byte-order input selects which memory byte appears in the low half of a host word. The memory side is a synchronous port with word addressing, byte enables and a read latency of one cycle.

Top module: `rdma_chan`

## Requirements
- R1: After reset the channel is idle (`busy` low), `done` is low, no memory strobe is active, and the current address reads back as 0.
- R2: Writing command 001 (read) or 010 (write) to offset 0 (bits [2:0]) loads the current address from the start address and the remaining count from the byte count. If the count is nonzero, `busy` rises after that clock edge.
- R3: Command 000 and command 011 written while idle are ignored. The channel stays idle, no completion pulse occurs, and the current address is unchanged.
- R4: Register offsets: 0 is the command. Offsets 1 and 2 are the start address low and high bytes. Offsets 3 and 4 are the byte count low and high bytes. Offsets 5 and 6 read the current address low and high bytes in bits [7:0]. Offset 7 is the data port.
- R5: Each data-port access in the active direction moves 1 byte in byte mode or 2 bytes in word mode. It advances the current address by that step and lowers the remaining count by that step, saturating at zero.
- R6: When the remaining count reaches zero, `busy` falls and `done` is high for exactly one cycle, in the cycle after the final access edge.
- R7: A command with bit 2 set stops a transfer immediately, produces no completion pulse, and leaves the current address at its last value.
- R8: In a read transfer, the data-port value is valid two clock edges after the start command or after the previous data-port read.
- R9: Byte mode: the byte at address A uses memory lane A[0] (lane 0 is `mem_*data[7:0]`, the even byte) and host bits [7:0]. Host read bits [15:8] are 0, and a write enables only that one lane.
- R10: Word mode: with `swap_bytes`=0, host bits [7:0] map to the even byte and [15:8] to the odd byte. With `swap_bytes`=1 the halves are exchanged. Writes enable both lanes.
- R11: Data-port accesses while idle cause no memory access and do not change the current address.
- R12: Starting a read or write with a byte count of 0 makes no memory access. `done` pulses in the cycle after the command edge, and the channel stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances a read transfer at offset 7) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data (byte registers use bits [7:0]) |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| word_mode | input | 1 | 1 = 16-bit transfers, 0 = byte transfers |
| swap_bytes | input | 1 | Byte order of a host word in word mode |
| mem_addr | output | 15 | Memory word address (current address bits [15:1]) |
| mem_re | output | 1 | Memory read strobe, data returned one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Memory byte-lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
A corrupted remaining count shows up as a `done` pulse on the wrong access, or none at all. The bench observes this on the access edge of the expected last transfer, by counting pulses. A wrong current address appears at once in the bench's memory image after a write, and in the next data value of a read. The address readback at offsets 5 and 6 confirms it two cycles after the transfer ends. Lane steering or byte-order faults change a single byte of the memory image or of the host read value, and a per-access compare catches this on that access.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } rdma_state_e;

   localparam logic [2:0] OFS_CMD     = 3'd0;
   localparam logic [2:0] OFS_START_L = 3'd1;
   localparam logic [2:0] OFS_START_H = 3'd2;
   localparam logic [2:0] OFS_COUNT_L = 3'd3;
   localparam logic [2:0] OFS_COUNT_H = 3'd4;
   localparam logic [2:0] OFS_CUR_L   = 3'd5;
   localparam logic [2:0] OFS_CUR_H   = 3'd6;
   localparam logic [2:0] OFS_DATA    = 3'd7;

   localparam logic [2:0] CMD_READ  = 3'b001;
   localparam logic [2:0] CMD_WRITE = 3'b010;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [2:0]    addr,
   input  logic [7:0]    wdata,
   output logic [AW-1:0] start_addr,
   output logic [CW-1:0] byte_count
);
   import rdma_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_addr <= '0;
         byte_count <= '0;
      end else if (wr) begin
         case (addr)
            OFS_START_L: start_addr[7:0]    <= wdata;
            OFS_START_H: start_addr[AW-1:8] <= wdata[AW-9:0];
            OFS_COUNT_L: byte_count[7:0]    <= wdata;
            OFS_COUNT_H: byte_count[CW-1:8] <= wdata[CW-9:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane #(
   parameter bit HAS_WORD = 1'b1
) (
   input  logic        word_mode,
   input  logic        swap,
   input  logic        byte_sel,
   input  logic [15:0] host_wdata,
   input  logic [15:0] mem_rdata,
   output logic [15:0] mem_wdata,
   output logic [1:0]  mem_be,
   output logic [15:0] host_rdata
);
   logic [15:0] b_wdata, b_rdata;
   logic [1:0]  b_be;

   always_comb begin
      b_wdata = {host_wdata[7:0], host_wdata[7:0]};
      b_be    = byte_sel ? 2'b10 : 2'b01;
      b_rdata = {8'h00, (byte_sel ? mem_rdata[15:8] : mem_rdata[7:0])};
   end

   if (HAS_WORD) begin : g_word
      always_comb begin
         if (word_mode) begin
            mem_be     = 2'b11;
            mem_wdata  = swap ? {host_wdata[7:0], host_wdata[15:8]} : host_wdata;
            host_rdata = swap ? {mem_rdata[7:0], mem_rdata[15:8]} : mem_rdata;
         end else begin
            mem_be     = b_be;
            mem_wdata  = b_wdata;
            host_rdata = b_rdata;
         end
      end
   end else begin : g_byte
      always_comb begin
         mem_be     = b_be;
         mem_wdata  = b_wdata;
         host_rdata = b_rdata;
      end
   end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_wr,
   input  logic [2:0]            cmd,
   input  logic [AW-1:0]         start_addr,
   input  logic [CW-1:0]         byte_count,
   input  logic                  port_acc,
   input  logic                  wide,
   output rdma_pkg::rdma_state_e state,
   output logic [AW-1:0]         cur_addr,
   output logic                  fetch,
   output logic                  fetch_dly,
   output logic                  done
);
   import rdma_pkg::*;

   logic [CW-1:0] remain;
   logic [CW-1:0] step_c;
   logic [AW-1:0] step_a;
   logic          last;

   assign step_c = wide ? CW'(2) : CW'(1);
   assign step_a = wide ? AW'(2) : AW'(1);
   assign last   = (remain <= step_c);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_addr  <= '0;
         remain    <= '0;
         fetch     <= 1'b0;
         fetch_dly <= 1'b0;
         done      <= 1'b0;
      end else begin
         done      <= 1'b0;
         fetch     <= 1'b0;
         fetch_dly <= fetch;
         if (cmd_wr) begin
            if (cmd[2]) begin
               state <= ST_IDLE;
            end else if (cmd == CMD_READ || cmd == CMD_WRITE) begin
               cur_addr <= start_addr;
               remain   <= byte_count;
               if (byte_count == '0) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  state <= (cmd == CMD_READ) ? ST_READ : ST_WRITE;
                  fetch <= (cmd == CMD_READ);
               end
            end
         end else if (port_acc && state != ST_IDLE) begin
            cur_addr <= cur_addr + step_a;
            remain   <= last ? '0 : remain - step_c;
            if (last) begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end else begin
               fetch <= (state == ST_READ);
            end
         end
      end
   end
endmodule

// File: rtl/rdma_chan.sv
module rdma_chan #(
   parameter int AW       = 16,
   parameter int CW       = 16,
   parameter bit HAS_WORD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [2:0]    reg_addr,
   input  logic [15:0]   reg_wdata,
   output logic [15:0]   reg_rdata,
   input  logic          word_mode,
   input  logic          swap_bytes,
   output logic [AW-2:0] mem_addr,
   output logic          mem_re,
   output logic          mem_we,
   output logic [1:0]    mem_be,
   output logic [15:0]   mem_wdata,
   input  logic [15:0]   mem_rdata,
   output logic          busy,
   output logic          done
);
   import rdma_pkg::*;

   localparam int HI_PAD = 24 - AW;

   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("rdma_chan: AW must lie in 9..16");
   end
   if (CW < 9 || CW > 16) begin : g_bad_cw
      $error("rdma_chan: CW must lie in 9..16");
   end

   rdma_state_e   state;
   logic [AW-1:0] start_addr;
   logic [CW-1:0] byte_count;
   logic [AW-1:0] cur_addr;
   logic          fetch, fetch_dly;
   logic          wide, cmd_wr, port_hit, port_acc;
   logic [15:0]   lane_rdata, rd_buf;

   assign wide     = HAS_WORD && word_mode;
   assign cmd_wr   = reg_wr && (reg_addr == OFS_CMD);
   assign port_hit = (reg_addr == OFS_DATA);
   assign mem_we   = reg_wr && port_hit && (state == ST_WRITE);
   assign port_acc = mem_we || (reg_rd && port_hit && (state == ST_READ));
   assign mem_re   = fetch;
   assign mem_addr = cur_addr[AW-1:1];
   assign busy     = (state != ST_IDLE);

   rdma_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata[7:0]),
      .start_addr (start_addr),
      .byte_count (byte_count)
   );

   rdma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd        (reg_wdata[2:0]),
      .start_addr (start_addr),
      .byte_count (byte_count),
      .port_acc   (port_acc),
      .wide       (wide),
      .state      (state),
      .cur_addr   (cur_addr),
      .fetch      (fetch),
      .fetch_dly  (fetch_dly),
      .done       (done)
   );

   rdma_lane #(.HAS_WORD(HAS_WORD)) u_lane (
      .word_mode  (wide),
      .swap       (swap_bytes),
      .byte_sel   (cur_addr[0]),
      .host_wdata (reg_wdata),
      .mem_rdata  (mem_rdata),
      .mem_wdata  (mem_wdata),
      .mem_be     (mem_be),
      .host_rdata (lane_rdata)
   );

   // prefetch holding register: loaded one cycle after the memory read strobe
   always_ff @(posedge clk) begin
      if (!rst_n)         rd_buf <= '0;
      else if (fetch_dly) rd_buf <= lane_rdata;
   end

   always_comb begin
      case (reg_addr)
         OFS_CUR_L: reg_rdata = {8'h00, cur_addr[7:0]};
         OFS_CUR_H: reg_rdata = {{HI_PAD{1'b0}}, cur_addr[AW-1:8]};
         OFS_DATA:  reg_rdata = rd_buf;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rdma_chk.sv
module rdma_chk #(
   parameter int AW       = 16,
   parameter bit HAS_WORD = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [2:0]    reg_addr,
   input logic [15:0]   reg_wdata,
   input logic          word_mode,
   input logic          mem_re,
   input logic          mem_we,
   input logic [1:0]    mem_be,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] cur_addr,
   input logic [AW-1:0] start_addr
);
   logic cmd_w;
   assign cmd_w = reg_wr && (reg_addr == 3'd0);

   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done);

   p_cmd_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && (reg_wdata[2:0] == 3'b001 || reg_wdata[2:0] == 3'b010))
      |=> cur_addr == $past(start_addr));

   p_ignored_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !busy && (reg_wdata[2:0] == 3'b000 || reg_wdata[2:0] == 3'b011))
      |=> !busy && !done && $stable(cur_addr));

   p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !(HAS_WORD && word_mode)) |=> cur_addr == $past(cur_addr) + AW'(1));

   p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && HAS_WORD && word_mode) |=> cur_addr == $past(cur_addr) + AW'(2));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && reg_wdata[2]) |=> !busy && !done && $stable(cur_addr));

   p_byte_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !(HAS_WORD && word_mode)) |-> $countones(mem_be) == 1);

   p_no_mem_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_re && !mem_we);
endmodule

bind rdma_chan rdma_chk #(.AW(AW), .HAS_WORD(HAS_WORD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .word_mode  (word_mode),
   .mem_re     (mem_re),
   .mem_we     (mem_we),
   .mem_be     (mem_be),
   .busy       (busy),
   .done       (done),
   .cur_addr   (cur_addr),
   .start_addr (start_addr)
);

// File: tb/tb_rdma_chan.sv
`timescale 1ns/1ps
module tb_rdma_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        word_mode = 1'b0, swap_bytes = 1'b0;
   logic [14:0] mem_addr;
   logic        mem_re, mem_we;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        busy, done;

   int n_chk = 0, n_fail = 0, done_seen = 0;

   logic [15:0] mem   [0:255];
   logic [7:0]  ref_b [0:511];

   always #2.5 clk = ~clk;

   rdma_chan dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .word_mode(word_mode), .swap_bytes(swap_bytes), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy), .done(done)
   );

   // memory model: 256 words, aliased on address bits [7:0]
   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_be[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
         if (mem_be[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
      end
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(posedge clk) if (rst_n && done) done_seen++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   function automatic logic [15:0] exp_rd(input logic [15:0] a, input bit w, input bit s);
      logic [8:0] e, o;
      e = {a[8:1], 1'b0};
      o = {a[8:1], 1'b1};
      if (!w) return {8'h00, ref_b[a[8:0]]};
      if (!s) return {ref_b[o], ref_b[e]};
      return {ref_b[e], ref_b[o]};
   endfunction

   task automatic put_ref(input logic [15:0] a, input bit w, input bit s, input logic [15:0] d);
      logic [8:0] e, o;
      e = {a[8:1], 1'b0};
      o = {a[8:1], 1'b1};
      if (!w) ref_b[a[8:0]] = d[7:0];
      else if (!s) begin ref_b[e] = d[7:0]; ref_b[o] = d[15:8]; end
      else begin ref_b[e] = d[15:8]; ref_b[o] = d[7:0]; end
   endtask

   function automatic int mem_mismatch();
      int bad = 0;
      for (int w = 0; w < 256; w++)
         if (mem[w] !== {ref_b[2*w+1], ref_b[2*w]}) bad++;
      return bad;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd_cur(output logic [15:0] c);
      logic [15:0] lo, hi;
      rd_reg(3'd5, lo);
      rd_reg(3'd6, hi);
      c = {hi[7:0], lo[7:0]};
   endtask

   task automatic run_xfer(input bit dir_wr, input bit w, input bit s,
                           input logic [15:0] st, input logic [15:0] cnt, input int abort_at);
      logic [15:0] a, d, got, c;
      int n, d0;
      bit aborted;
      @(negedge clk);
      word_mode = w; swap_bytes = s;
      wr_reg(3'd1, {8'h00, st[7:0]});
      wr_reg(3'd2, {8'h00, st[15:8]});
      wr_reg(3'd3, {8'h00, cnt[7:0]});
      wr_reg(3'd4, {8'h00, cnt[15:8]});
      n = w ? (int'(cnt) + 1) / 2 : int'(cnt);
      a = st;
      d0 = done_seen;
      aborted = (abort_at >= 0) && (abort_at < n);
      wr_reg(3'd0, dir_wr ? 16'h0002 : 16'h0001);
      if (n == 0) begin
         chk(done == 1'b1, "R12 done after zero-count start", done, 1);
         chk(busy == 1'b0, "R12 idle after zero-count start", busy, 0);
      end else begin
         chk(busy == 1'b1, "R2 busy after start command", busy, 1);
      end
      for (int i = 0; i < n; i++) begin
         if (i == abort_at) break;
         if (dir_wr) begin
            d = 16'($urandom);
            put_ref(a, w, s, d);
            wr_reg(3'd7, d);
         end else begin
            idle(2);
            rd_reg(3'd7, got);
            chk(got == exp_rd(a, w, s), w ? "R10 R8 word read data" : "R9 R8 byte read data",
                got, exp_rd(a, w, s));
         end
         a = a + (w ? 16'd2 : 16'd1);
         if (i == n - 1) chk(done == 1'b1, "R6 done after last access", done, 1);
      end
      if (aborted) begin
         wr_reg(3'd0, 16'h0004);
         chk(busy == 1'b0, "R7 idle after abort", busy, 0);
      end
      idle(2);
      rd_cur(c);
      chk(c == a, aborted ? "R7 address kept after abort" : "R4 R5 current address readback",
          c, a);
      chk((done_seen - d0) == (aborted ? 0 : 1), "R6 R7 completion pulse count",
          done_seen - d0, aborted ? 0 : 1);
      chk(busy == 1'b0, "R6 idle at end", busy, 0);
      if (dir_wr) chk(mem_mismatch() == 0, w ? "R10 memory image" : "R9 memory image",
                      mem_mismatch(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      report();
      $finish;
   end

   initial begin
      logic [15:0] c0, c1, junk;
      void'($urandom(32'd1357));
      for (int i = 0; i < 256; i++) begin
         mem[i] = 16'($urandom);
         ref_b[2*i]   = mem[i][7:0];
         ref_b[2*i+1] = mem[i][15:8];
      end
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      chk(done == 1'b0, "R1 done after reset", done, 0);
      chk(!mem_re && !mem_we, "R1 memory strobes after reset", {mem_re, mem_we}, 0);
      rd_cur(c0);
      chk(c0 == 16'h0000, "R1 current address after reset", c0, 0);

      // directed transfers
      run_xfer(1'b1, 1'b0, 1'b0, 16'h0010, 16'd3, -1);   // byte write, odd start after
      run_xfer(1'b0, 1'b0, 1'b0, 16'h0011, 16'd4, -1);   // byte read, odd start
      run_xfer(1'b1, 1'b1, 1'b0, 16'h0040, 16'd6, -1);   // word write
      run_xfer(1'b1, 1'b1, 1'b1, 16'h0050, 16'd5, -1);   // word write swapped, odd count clamps
      run_xfer(1'b0, 1'b1, 1'b1, 16'h0050, 16'd4, -1);   // word read swapped
      run_xfer(1'b0, 1'b1, 1'b0, 16'hFFFE, 16'd4, -1);   // address wrap
      run_xfer(1'b1, 1'b0, 1'b0, 16'h0100, 16'd8, 3);    // abort mid-write
      run_xfer(1'b0, 1'b1, 1'b0, 16'h0120, 16'd8, 0);    // abort right after start
      run_xfer(1'b1, 1'b0, 1'b0, 16'h0200, 16'd0, -1);   // R12 zero count

      // R3 ignored commands
      rd_cur(c0);
      begin
         int d0;
         d0 = done_seen;
         wr_reg(3'd0, 16'h0000);
         chk(busy == 1'b0, "R3 command 000 ignored", busy, 0);
         wr_reg(3'd0, 16'h0003);
         chk(busy == 1'b0, "R3 command 011 ignored", busy, 0);
         idle(2);
         chk(done_seen == d0, "R3 no completion pulse", done_seen - d0, 0);
      end
      rd_cur(c1);
      chk(c1 == c0, "R3 current address unchanged", c1, c0);

      // R11 idle data-port accesses
      wr_reg(3'd7, 16'hBEEF);
      rd_reg(3'd7, junk);
      chk(mem_mismatch() == 0, "R11 memory unchanged by idle port write", mem_mismatch(), 0);
      rd_cur(c1);
      chk(c1 == c0, "R11 current address unchanged", c1, c0);

      // constrained random transfers
      for (int k = 0; k < 40; k++) begin
         bit dw, ww, ss;
         logic [15:0] st, cn;
         int ab;
         dw = 1'($urandom);
         ww = 1'($urandom);
         ss = 1'($urandom);
         st = 16'($urandom);
         if (ww) st[0] = 1'b0;
         cn = 16'($urandom_range(1, 8));
         ab = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 3)) : -1;
         run_xfer(dw, ww, ss, st, cn, ab);
      end

      report();
      $finish;
   end
endmodule